// File: doc/BRIEF.md
# Actuator Homing Start-Up Sequencer

This block brings a piezoelectric actuator to a known position each time the driver is switched on. When enable is seen high while the block is idle, it runs a fixed three-phase homing routine. First it asks the drive-waveform generator to run toward the infinity end for a long stretch. Then it holds still for a short settle interval. Finally it runs a short distance back toward the macro end. Every stretch is measured in units of a fixed number of waveform cycles. The generator reports the end of each cycle with a one-clock strobe. During the settle interval the generator is stopped, so the block times each cycle itself from the clock.

While the routine runs, a busy flag is held high, and this includes the settle interval. Once the routine completes, busy drops and a done flag rises, which lets the downstream command logic accept drive pulses. Pulling enable low at any time abandons the routine and clears done. The next time enable is high, the whole routine starts again from the beginning.

Top module: `home_seq_top`

## Requirements
- R1: After a synchronous active-low reset, `run_req`, `run_dir`, `init_busy` and `init_done` are all 0.
- R2: When `enable` is sampled 1 while the block is idle (not running and not done), from the next clock `run_req`=1, `run_dir`=0 (0 encodes the infinity direction) and `init_busy`=1.
- R3: The infinity phase ends on the clock edge that samples the (PH1_UNITS*CYCLES_PER_UNIT)-th `cyc_strobe` counted since the phase began. The settle phase then starts on the next clock.
- R4: During the settle phase `run_req`=0, `run_dir`=0 and `init_busy`=1. The phase lasts exactly PH2_UNITS*CYCLES_PER_UNIT*CLKS_PER_CYCLE clocks, and `cyc_strobe` has no effect on its length.
- R5: After the settle phase, `run_req`=1 and `run_dir`=1 (1 encodes the macro direction) until the edge that samples the (PH3_UNITS*CYCLES_PER_UNIT)-th strobe of that phase.
- R6: `init_busy` is 1 exactly while one of the three phases is active. `init_done` rises on the clock after the macro phase ends and stays 1 for as long as `enable` stays 1. The two flags are never 1 together.
- R7: When `enable` is sampled 0 in any state, all four outputs are 0 from the next clock. A later `enable`=1 restarts the sequence at the infinity phase with fresh counts.
- R8: `cyc_strobe` pulses while the block is idle or done change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (one tick per waveform clock) |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Driver on; low means standby |
| cyc_strobe | input | 1 | One-clock pulse at the end of each generator cycle |
| run_req | output | 1 | Asks the generator to run |
| run_dir | output | 1 | Direction of the run: 0 infinity, 1 macro |
| init_busy | output | 1 | Homing in progress (feeds BUSY) |
| init_done | output | 1 | Homing finished; drive commands may be accepted |

## Verification
The assertions assume that `cyc_strobe` is a single-clock pulse. They also assume that the block itself, not the inputs, decides when the settle phase ends. Strobes that arrive while the generator would be stopped are allowed, and must simply be ignored. The bench drives strobes from a free-running pulse source with an adjustable period, including a pulse on every clock. That source keeps running through idle, settle and done, so that ignored strobes are exercised. Enable is toggled only at clock mid-points, and it is dropped inside each phase to check the abort path.

// File: rtl/home_seq_pkg.sv
// Shared types for the homing sequencer.
package home_seq_pkg;
    // Sequencer states; order is not decoded outside the top.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_TOINF  = 3'd1,
        ST_SETTLE = 3'd2,
        ST_TOMAC  = 3'd3,
        ST_DONE   = 3'd4
    } seq_state_t;
endpackage

// File: rtl/home_cycle_timer.sv
// Internal cycle timer: while `active` is high it emits a one-clock tick
// every CLKS_PER_CYCLE clocks. It stands in for the generator's strobe
// while the generator is stopped. It assumes `active` is dropped between uses.
module home_cycle_timer #(
    parameter int CLKS_PER_CYCLE = 87
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic tick
);
    localparam int CW = $clog2(CLKS_PER_CYCLE + 1);
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_CYCLE - 1);

    logic [CW-1:0] cnt;

    // Count clocks within one cycle; restart whenever inactive or at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || cnt == LAST) cnt <= '0;
        else                                  cnt <= cnt + 1'b1;
    end

    assign tick = active && (cnt == LAST);

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);                                               // R4
    AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick || (CLKS_PER_CYCLE == 1));                   // R4
endmodule

// File: rtl/home_unit_counter.sv
// Phase length counter: counts `step` pulses in units of CYCLES_PER_UNIT.
// It raises `phase_end` combinationally on the step that completes
// `unit_limit` units. It assumes `clear` is asserted between phases and
// that `unit_limit` is at least 1.
module home_unit_counter #(
    parameter int CYCLES_PER_UNIT = 140,
    parameter int UNIT_W          = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [UNIT_W-1:0] unit_limit,
    output logic              phase_end
);
    localparam int CYW = $clog2(CYCLES_PER_UNIT + 1);
    localparam logic [CYW-1:0] CYC_LAST = CYW'(CYCLES_PER_UNIT - 1);

    logic [CYW-1:0]    cyc;
    logic [UNIT_W-1:0] unit;
    logic              unit_wrap;

    assign unit_wrap = step && (cyc == CYC_LAST);
    assign phase_end = unit_wrap && (unit == unit_limit - UNIT_W'(1));

    // Cycle position within the current unit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || unit_wrap) cyc <= '0;
        else if (step)                    cyc <= cyc + 1'b1;
    end

    // Completed units within the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || phase_end) unit <= '0;
        else if (unit_wrap)               unit <= unit + 1'b1;
    end

    AST_CYC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc <= CYC_LAST);                                           // R3
    AST_UNIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        clear || unit < unit_limit);                                // R5
endmodule

// File: rtl/home_seq_top.sv
// Start-up homing sequencer. When enable is high in idle it runs an
// infinity-direction drive, then a settle wait with no drive, then a
// macro-direction drive. It then holds done until enable drops.
// Assumes cyc_strobe is a one-clock pulse from the waveform generator.
module home_seq_top #(
    parameter int CYCLES_PER_UNIT = 140,
    parameter int CLKS_PER_CYCLE  = 87,
    parameter int PH1_UNITS       = 170,
    parameter int PH2_UNITS       = 4,
    parameter int PH3_UNITS       = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cyc_strobe,
    output logic run_req,
    output logic run_dir,
    output logic init_busy,
    output logic init_done
);
    import home_seq_pkg::*;

    localparam int MAXU   = (PH1_UNITS > PH2_UNITS) ?
                            ((PH1_UNITS > PH3_UNITS) ? PH1_UNITS : PH3_UNITS) :
                            ((PH2_UNITS > PH3_UNITS) ? PH2_UNITS : PH3_UNITS);
    localparam int UNIT_W = $clog2(MAXU + 1);

    seq_state_t        state, state_nx;
    logic              tick, step, phase_end, clr;
    logic [UNIT_W-1:0] limit;

    // Settle-phase cycle timer (generator is stopped then).
    home_cycle_timer #(.CLKS_PER_CYCLE(CLKS_PER_CYCLE)) timer_i (
        .clk(clk), .rst_n(rst_n),
        .active(state == ST_SETTLE && enable),
        .tick(tick)
    );

    // Select the count source and the unit limit for the active phase.
    always_comb begin
        step  = 1'b0;
        limit = UNIT_W'(PH1_UNITS);
        case (state)
            ST_TOINF:  begin step = cyc_strobe; limit = UNIT_W'(PH1_UNITS); end
            ST_SETTLE: begin step = tick;       limit = UNIT_W'(PH2_UNITS); end
            ST_TOMAC:  begin step = cyc_strobe; limit = UNIT_W'(PH3_UNITS); end
            default:   begin step = 1'b0;       limit = UNIT_W'(PH1_UNITS); end
        endcase
    end

    assign clr = !enable || phase_end || state == ST_IDLE || state == ST_DONE;

    home_unit_counter #(.CYCLES_PER_UNIT(CYCLES_PER_UNIT), .UNIT_W(UNIT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .clear(clr), .step(step),
        .unit_limit(limit), .phase_end(phase_end)
    );

    // Next-state decision; enable low overrides everything.
    always_comb begin
        state_nx = state;
        if (!enable) state_nx = ST_IDLE;
        else begin
            case (state)
                ST_IDLE:   state_nx = ST_TOINF;
                ST_TOINF:  if (phase_end) state_nx = ST_SETTLE;
                ST_SETTLE: if (phase_end) state_nx = ST_TOMAC;
                ST_TOMAC:  if (phase_end) state_nx = ST_DONE;
                default:   state_nx = ST_DONE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign run_req   = (state == ST_TOINF) || (state == ST_TOMAC);
    assign run_dir   = (state == ST_TOMAC);
    assign init_busy = (state == ST_TOINF) || (state == ST_SETTLE) || (state == ST_TOMAC);
    assign init_done = (state == ST_DONE);

    AST_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && enable) |=> (run_req && !run_dir));      // R2
    AST_INF_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TOINF && enable) |=> (state == ST_TOINF || state == ST_SETTLE)); // R3
    AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |-> (!run_req && init_busy));           // R4
    AST_MAC_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TOMAC && enable) |=> (state == ST_TOMAC || state == ST_DONE)); // R5
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_busy && init_done));                                  // R6
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && enable) |=> init_done);                        // R6
    AST_EN_LOW_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!run_req && !init_busy && !init_done));         // R7
    AST_IDLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && enable && cyc_strobe) |=> init_done);          // R8
endmodule

// File: tb/home_seq_top_tb_top.sv
// Self-checking bench: behavioural reference compared on every clock.
module home_seq_top_tb_top;
    localparam int CPU = 3, CPC = 5, U1 = 4, U2 = 2, U3 = 2;

    logic clk = 0, rst_n = 0, enable = 0, cyc_strobe = 0;
    logic run_req, run_dir, init_busy, init_done;
    int total = 0, bad = 0, period = 3, pcnt = 0, clocks = 0;
    int ms = 0, mcnt = 0;   // model: 0 idle,1 inf,2 settle,3 macro,4 done

    always #10 clk = ~clk;

    home_seq_top #(.CYCLES_PER_UNIT(CPU), .CLKS_PER_CYCLE(CPC),
                   .PH1_UNITS(U1), .PH2_UNITS(U2), .PH3_UNITS(U3)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cyc_strobe(cyc_strobe),
        .run_req(run_req), .run_dir(run_dir),
        .init_busy(init_busy), .init_done(init_done));

    // Reference model: counts strobes per phase, clocks during settle.
    always @(posedge clk) begin
        if (!rst_n || !enable) begin ms = (!rst_n || !enable) ? 0 : ms; mcnt = 0; end
        else case (ms)
            0: begin ms = 1; mcnt = 0; end
            1: if (cyc_strobe) begin mcnt++; if (mcnt == U1*CPU) begin ms = 2; mcnt = 0; end end
            2: begin mcnt++; if (mcnt == U2*CPU*CPC) begin ms = 3; mcnt = 0; end end
            3: if (cyc_strobe) begin mcnt++; if (mcnt == U3*CPU) begin ms = 4; mcnt = 0; end end
            default: ms = 4;
        endcase
    end

    // Free-running strobe source, changed at the falling edge.
    always @(negedge clk) begin
        pcnt++;
        if (pcnt >= period) begin cyc_strobe <= 1; pcnt = 0; end
        else cyc_strobe <= 0;
    end

    function automatic string tag(int s);
        case (s) 0: return "R8"; 1: return "R3"; 2: return "R4";
                 3: return "R5"; default: return "R6"; endcase
    endfunction

    // Per-clock comparison against the model, before the inputs move.
    always @(negedge clk) begin
        logic [3:0] exp_v, act_v;
        clocks++;
        if (rst_n) begin
            exp_v = {ms == 1 || ms == 3, ms == 3, ms >= 1 && ms <= 3, ms == 4};
            act_v = {run_req, run_dir, init_busy, init_done};
            total++;
            if (act_v !== exp_v) begin
                bad++;
                $display("FAIL %s state=%0d act=%b exp=%b", tag(ms), ms, act_v, exp_v);
            end
        end
        if (clocks > 100000) begin
            bad++; total++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(string r, logic [3:0] act, logic [3:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s act=%b exp=%b", r, act, exp_v);
        end
    endtask

    task automatic wait_ms(int s);
        for (int i = 0; i < 5000 && ms != s; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clks(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        clks(3);
        check("R1", {run_req, run_dir, init_busy, init_done}, 4'b0000);
        rst_n = 1; clks(4);
        check("R1", {run_req, run_dir, init_busy, init_done}, 4'b0000);
        // R2 start, full run with strobes every 3 clocks
        enable = 1; clks(1);
        check("R2", {run_req, run_dir, init_busy, init_done}, 4'b1010);
        wait_ms(4); clks(1);
        check("R6", {run_req, run_dir, init_busy, init_done}, 4'b0001);
        clks(20);   // R8: strobes keep arriving while done
        check("R8", {run_req, run_dir, init_busy, init_done}, 4'b0001);
        // R7 drop enable after done
        enable = 0; clks(1);
        check("R7", {run_req, run_dir, init_busy, init_done}, 4'b0000);
        clks(10);
        check("R8", {run_req, run_dir, init_busy, init_done}, 4'b0000);
        // strobe every clock, abort mid infinity phase
        period = 1; enable = 1; clks(5); enable = 0; clks(1);
        check("R7", {run_req, run_dir, init_busy, init_done}, 4'b0000);
        // abort during settle with strobes every clock
        enable = 1; wait_ms(2); clks(7);
        check("R4", {run_req, run_dir, init_busy, init_done}, 4'b0010);
        enable = 0; clks(1);
        check("R7", {run_req, run_dir, init_busy, init_done}, 4'b0000);
        // slow strobes, abort during macro phase then full restart
        period = 7; enable = 1; wait_ms(3); clks(2);
        check("R5", {run_req, run_dir, init_busy, init_done}, 4'b1110);
        enable = 0; clks(1);
        check("R7", {run_req, run_dir, init_busy, init_done}, 4'b0000);
        enable = 1; clks(1);
        check("R2", {run_req, run_dir, init_busy, init_done}, 4'b1010);
        wait_ms(4); clks(3);
        check("R6", {run_req, run_dir, init_busy, init_done}, 4'b0001);
        // reset in the middle returns all outputs low
        enable = 0; clks(2); enable = 1; clks(4); rst_n = 0; clks(1);
        check("R1", {run_req, run_dir, init_busy, init_done}, 4'b0000);
        rst_n = 1; enable = 0; clks(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule